// File: doc/BRIEF.md
# Cache-Operation Permission Checker

This block settles the protection verdict for every storage access and cache-maintenance operation that a load/store pipeline issues. Each cycle it may accept one operation: a valid strobe, an operation code, the current privilege mode, and the four permission bits of the already-translated page. These bits are user read, user write, supervisor read and supervisor write. One clock later it reports exactly one verdict. The verdict is one of: proceed, complete silently as a no-op, take a data storage interrupt of read or write type, or take a privileged-instruction exception.

The check applied to a cache operation follows what the operation does to memory, not what it is called. Operations that can change memory contents (zeroing a line, discarding a data line) are checked for write rights. Operations that only move or drop clean copies (flush, clean, instruction-line discard) are checked for read rights. Prefetch hints that fail their read check are quietly dropped rather than trapping. A whole-cache wipe needs no page rights. In supervisor mode it proceeds and raises a one-cycle flash-invalidate request for the data or instruction cache. In user mode it is refused as privileged.

Top module: `cop_perm_check`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release before any strobe, `out_valid` and every verdict flag are 0, whatever the inputs.
- R2: A verdict appears exactly one clock after `in_valid` is sampled high and lasts one cycle. When `out_valid` is 1, exactly one of `out_proceed`, `out_nop`, `out_dsi`, `out_priv` is 1. When `out_valid` is 0, all flags are 0.
- R3: The rights checked are `perm_sr`/`perm_sw` when `in_super` is 1 and `perm_ur`/`perm_uw` when `in_super` is 0. The bits of the other mode have no effect.
- R4: Code 0 (load) is checked for read rights and code 1 (store) for write rights. A failure gives `out_dsi`=1, with `out_dsi_write`=0 for read type and 1 for write type. A pass gives `out_proceed`.
- R5: Code 2 (line zero) and code 3 (data line discard) are checked for write rights only. A failure gives a write-type data storage interrupt.
- R6: Code 4 (line reserve) always gives `out_nop`, for any mode and any permission bits.
- R7: Code 5 (instruction line discard) is checked for read rights. A failure gives a read-type data storage interrupt.
- R8: Codes 6 (read prefetch), 7 (store prefetch) and 8 (instruction prefetch) are checked for read rights. A failure gives `out_nop` and never `out_dsi`.
- R9: Code 9 (line flush) and code 10 (line clean) are checked for read rights only. Write rights are ignored. A failure gives a read-type data storage interrupt.
- R10: Code 11 (data cache wipe) and code 12 (instruction cache wipe) in supervisor mode give `out_proceed` together with `out_wipe_d` or `out_wipe_i` respectively, whatever the permission bits.
- R11: Code 11 or 12 in user mode gives `out_priv` and neither wipe request.
- R12: Codes 13 to 15 give `out_nop`.
- R13: `out_dsi_write` is 1 only together with `out_dsi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | OP_W | Operation code |
| in_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| perm_ur | input | 1 | User read right of the page |
| perm_uw | input | 1 | User write right of the page |
| perm_sr | input | 1 | Supervisor read right of the page |
| perm_sw | input | 1 | Supervisor write right of the page |
| out_valid | output | 1 | Verdict valid |
| out_proceed | output | 1 | Operation may proceed |
| out_nop | output | 1 | Operation completes as a no-op |
| out_dsi | output | 1 | Data storage interrupt |
| out_dsi_write | output | 1 | Interrupt type: 1 write, 0 read |
| out_priv | output | 1 | Privileged-instruction exception |
| out_wipe_d | output | 1 | Flash-invalidate the data cache |
| out_wipe_i | output | 1 | Flash-invalidate the instruction cache |

## Verification
The flash-invalidate request and the proceed verdict come out in the same cycle. That pairing must hold even when every permission bit is clear. To provoke it, the bench issues a supervisor wipe on a page with no rights. It follows at once with an access that traps, so a wipe flag left over from the first verdict would land on the trapping one. Each cycle is judged on the full flag vector. The wipe cycle must show proceed plus the one correct wipe line and no interrupt. The next cycle must show the interrupt with both wipe lines low.

// File: rtl/cop_pkg.sv
package cop_pkg;

  localparam int N_RIGHTS = 2;  // index 0 = read, 1 = write
  localparam int RD = 0;
  localparam int WR = 1;

  localparam int OPC_LOAD      = 0;
  localparam int OPC_STORE     = 1;
  localparam int OPC_ZERO      = 2;
  localparam int OPC_DDISCARD  = 3;
  localparam int OPC_RESERVE   = 4;
  localparam int OPC_IDISCARD  = 5;
  localparam int OPC_PF_RD     = 6;
  localparam int OPC_PF_WR     = 7;
  localparam int OPC_PF_INS    = 8;
  localparam int OPC_FLUSH     = 9;
  localparam int OPC_CLEAN     = 10;
  localparam int OPC_WIPE_D    = 11;
  localparam int OPC_WIPE_I    = 12;

  typedef enum logic [2:0] {
    CK_NOP        = 3'd0,
    CK_READ_TRAP  = 3'd1,
    CK_WRITE_TRAP = 3'd2,
    CK_READ_HINT  = 3'd3,
    CK_WIPE_D     = 3'd4,
    CK_WIPE_I     = 3'd5
  } chk_e;

  typedef struct packed {
    logic proceed;
    logic nop;
    logic dsi;
    logic dsi_wr;
    logic priv;
    logic wipe_d;
    logic wipe_i;
  } verdict_t;

  // Map an operation code onto the kind of check its effect calls for.
  function automatic chk_e classify(input int unsigned op);
    chk_e k;
    case (op)
      OPC_LOAD, OPC_IDISCARD, OPC_FLUSH, OPC_CLEAN: k = CK_READ_TRAP;
      OPC_STORE, OPC_ZERO, OPC_DDISCARD:            k = CK_WRITE_TRAP;
      OPC_PF_RD, OPC_PF_WR, OPC_PF_INS:             k = CK_READ_HINT;
      OPC_WIPE_D:                                   k = CK_WIPE_D;
      OPC_WIPE_I:                                   k = CK_WIPE_I;
      default:                                      k = CK_NOP;
    endcase
    return k;
  endfunction

  // Turn a check kind plus the selected rights into one verdict.
  function automatic verdict_t decide(input chk_e kind, input logic sup,
                                      input logic rd_ok, input logic wr_ok);
    verdict_t v;
    v = '0;
    case (kind)
      CK_READ_TRAP: begin
        if (rd_ok) v.proceed = 1'b1;
        else       v.dsi     = 1'b1;
      end
      CK_WRITE_TRAP: begin
        if (wr_ok) v.proceed = 1'b1;
        else begin
          v.dsi    = 1'b1;
          v.dsi_wr = 1'b1;
        end
      end
      CK_READ_HINT: begin
        if (rd_ok) v.proceed = 1'b1;
        else       v.nop     = 1'b1;
      end
      CK_WIPE_D: begin
        if (sup) begin
          v.proceed = 1'b1;
          v.wipe_d  = 1'b1;
        end else v.priv = 1'b1;
      end
      CK_WIPE_I: begin
        if (sup) begin
          v.proceed = 1'b1;
          v.wipe_i  = 1'b1;
        end else v.priv = 1'b1;
      end
      default: v.nop = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cop_classify.sv
module cop_classify
  import cop_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op,
  output chk_e            kind
);
  always_comb kind = classify(32'(op));
endmodule

// File: rtl/cop_perm_sel.sv
module cop_perm_sel
  import cop_pkg::*;
(
  input  logic                sup,
  input  logic [N_RIGHTS-1:0] usr_rights,
  input  logic [N_RIGHTS-1:0] sup_rights,
  output logic [N_RIGHTS-1:0] eff_rights
);
  for (genvar g = 0; g < N_RIGHTS; g++) begin : g_right
    assign eff_rights[g] = sup ? sup_rights[g] : usr_rights[g];
  end
endmodule

// File: rtl/cop_verdict.sv
module cop_verdict
  import cop_pkg::*;
(
  input  chk_e     kind,
  input  logic     sup,
  input  logic     rd_ok,
  input  logic     wr_ok,
  output verdict_t v
);
  always_comb v = decide(kind, sup, rd_ok, wr_ok);
endmodule

// File: rtl/cop_perm_check.sv
module cop_perm_check
  import cop_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic            in_super,
  input  logic            perm_ur,
  input  logic            perm_uw,
  input  logic            perm_sr,
  input  logic            perm_sw,
  output logic            out_valid,
  output logic            out_proceed,
  output logic            out_nop,
  output logic            out_dsi,
  output logic            out_dsi_write,
  output logic            out_priv,
  output logic            out_wipe_d,
  output logic            out_wipe_i
);

  // named internal events
  chk_e                cur_kind;
  logic [N_RIGHTS-1:0] usr_rights;
  logic [N_RIGHTS-1:0] sup_rights;
  logic [N_RIGHTS-1:0] eff_rights;
  verdict_t            next_v;
  verdict_t            out_q;
  logic                valid_q;
  logic                armed;

  assign usr_rights = {perm_uw, perm_ur};
  assign sup_rights = {perm_sw, perm_sr};

  cop_classify #(.OP_W(OP_W)) u_cls (
    .op   (in_op),
    .kind (cur_kind)
  );

  cop_perm_sel u_sel (
    .sup        (in_super),
    .usr_rights (usr_rights),
    .sup_rights (sup_rights),
    .eff_rights (eff_rights)
  );

  cop_verdict u_dec (
    .kind  (cur_kind),
    .sup   (in_super),
    .rd_ok (eff_rights[RD]),
    .wr_ok (eff_rights[WR]),
    .v     (next_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
      armed   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      out_q   <= in_valid ? next_v : '0;
      armed   <= 1'b1;
    end
  end

  assign out_valid     = valid_q;
  assign out_proceed   = out_q.proceed;
  assign out_nop       = out_q.nop;
  assign out_dsi       = out_q.dsi;
  assign out_dsi_write = out_q.dsi_wr;
  assign out_priv      = out_q.priv;
  assign out_wipe_d    = out_q.wipe_d;
  assign out_wipe_i    = out_q.wipe_i;

  // ---------------- assertions ----------------
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_proceed, out_nop, out_dsi, out_priv}));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ({out_proceed, out_nop, out_dsi, out_dsi_write,
                     out_priv, out_wipe_d, out_wipe_i} == 7'd0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  assert_hint_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_kind == CK_READ_HINT) |=> !out_dsi);

  assert_wipe_super_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (out_wipe_d || out_wipe_i)) |->
      (out_proceed && !(out_wipe_d && out_wipe_i) && $past(in_super)));

  assert_user_wipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_super && (cur_kind == CK_WIPE_D || cur_kind == CK_WIPE_I))
      |=> (out_priv && !out_wipe_d && !out_wipe_i));

  assert_reserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && 32'(in_op) == OPC_RESERVE) |=> out_nop);

  assert_dsi_type_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_dsi_write |-> out_dsi);

endmodule

// File: tb/sim_cop_perm_check.sv
`timescale 1ns/1ps
module sim_cop_perm_check;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic       in_super = 1'b0;
  logic       perm_ur = 1'b0, perm_uw = 1'b0, perm_sr = 1'b0, perm_sw = 1'b0;
  logic out_valid, out_proceed, out_nop, out_dsi, out_dsi_write;
  logic out_priv, out_wipe_d, out_wipe_i;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  cop_perm_check #(.OP_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_super(in_super), .perm_ur(perm_ur), .perm_uw(perm_uw),
    .perm_sr(perm_sr), .perm_sw(perm_sw), .out_valid(out_valid),
    .out_proceed(out_proceed), .out_nop(out_nop), .out_dsi(out_dsi),
    .out_dsi_write(out_dsi_write), .out_priv(out_priv),
    .out_wipe_d(out_wipe_d), .out_wipe_i(out_wipe_i)
  );

  // flag vector order: proceed nop dsi dsi_write priv wipe_d wipe_i
  function automatic logic [6:0] got_flags();
    return {out_proceed, out_nop, out_dsi, out_dsi_write, out_priv,
            out_wipe_d, out_wipe_i};
  endfunction

  // Independent reference, written per operation code from the requirements.
  function automatic logic [6:0] ref_flags(input int op, input bit sup,
      input bit ur, input bit uw, input bit sr, input bit sw);
    bit r, w;
    r = sup ? sr : ur;
    w = sup ? sw : uw;
    if (op == 0 || op == 5 || op == 9 || op == 10)
      return r ? 7'b1000000 : 7'b0010000;
    if (op == 1 || op == 2 || op == 3)
      return w ? 7'b1000000 : 7'b0011000;
    if (op >= 6 && op <= 8)
      return r ? 7'b1000000 : 7'b0100000;
    if (op == 11) return sup ? 7'b1000010 : 7'b0000100;
    if (op == 12) return sup ? 7'b1000001 : 7'b0000100;
    return 7'b0100000;  // code 4 and codes 13..15
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1:        return "R4";
      2, 3:        return "R5";
      4:           return "R6";
      5:           return "R7";
      6, 7, 8:     return "R8";
      9, 10:       return "R9";
      11, 12:      return "R10/R11";
      default:     return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual valid+flags=%b expected=%b", tag, act, exp);
    end
  endtask

  // Called at a negedge: apply one op, wait one negedge, compare.
  task automatic drive(input int op, input bit sup, input bit ur, input bit uw,
                       input bit sr, input bit sw, input string tag);
    in_valid = 1'b1;
    in_op    = 4'(op);
    in_super = sup;
    perm_ur = ur; perm_uw = uw; perm_sr = sr; perm_sw = sw;
    @(negedge clk);
    check(tag, {out_valid, got_flags()},
          {1'b1, ref_flags(op, sup, ur, uw, sr, sw)});
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0;
    in_op    = 4'd11;
    in_super = 1'b1;
    @(negedge clk);
    check(tag, {out_valid, got_flags()}, 8'd0);
  endtask

  task automatic t_reset;
    in_valid = 1'b1; in_op = 4'd11; in_super = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", {out_valid, got_flags()}, 8'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {out_valid, got_flags()}, 8'd0);
  endtask

  task automatic t_mode_select;
    drive(0, 1, 1, 1, 0, 0, "R3 super ignores user read");
    drive(0, 0, 1, 0, 0, 0, "R3 user read used");
    drive(1, 0, 1, 0, 1, 1, "R3 user ignores super write");
    drive(1, 1, 0, 0, 1, 1, "R3 super write used");
    idle("R2 gap");
  endtask

  task automatic t_load_store;
    drive(0, 0, 0, 1, 1, 1, "R4 load read trap");
    drive(1, 0, 1, 0, 1, 1, "R4 store write trap");
    drive(0, 1, 0, 0, 1, 0, "R4 load ok");
    drive(1, 1, 0, 0, 0, 1, "R4 store ok");
    idle("R2 gap");
  endtask

  task automatic t_write_class;
    drive(2, 0, 1, 0, 0, 0, "R5 zero no write");
    drive(3, 1, 0, 0, 1, 0, "R5 discard no write");
    drive(3, 1, 0, 0, 0, 1, "R5 discard write only");
    idle("R2 gap");
  endtask

  task automatic t_reserve;
    drive(4, 0, 0, 0, 0, 0, "R6 reserve no rights");
    drive(4, 1, 1, 1, 1, 1, "R6 reserve all rights");
    idle("R6 idle");
  endtask

  task automatic t_idiscard;
    drive(5, 0, 0, 1, 1, 1, "R7 idiscard read fail");
    drive(5, 1, 0, 0, 1, 0, "R7 idiscard ok");
    idle("R2 gap");
  endtask

  task automatic t_prefetch;
    drive(6, 0, 0, 1, 0, 0, "R8 read prefetch drop");
    drive(7, 1, 0, 0, 0, 1, "R8 store prefetch drop");
    drive(8, 1, 0, 0, 1, 0, "R8 instr prefetch ok");
    idle("R2 gap");
  endtask

  task automatic t_flush_clean;
    drive(9,  0, 1, 0, 0, 0, "R9 flush no write ok");
    drive(10, 1, 0, 0, 1, 0, "R9 clean no write ok");
    drive(9,  1, 0, 0, 0, 1, "R9 flush read trap");
    drive(10, 0, 0, 1, 0, 0, "R9 clean read trap");
    idle("R13 gap");
  endtask

  task automatic t_wipe_collide;
    drive(11, 1, 0, 0, 0, 0, "R10 wipe d no rights");
    drive(1,  1, 0, 0, 0, 0, "R13 trap after wipe");
    drive(12, 1, 0, 0, 0, 0, "R10 wipe i no rights");
    drive(0,  0, 0, 0, 1, 1, "R4 trap after wipe");
    idle("R2 wipe released");
  endtask

  task automatic t_wipe_user;
    drive(11, 0, 1, 1, 1, 1, "R11 user wipe d");
    drive(12, 0, 1, 1, 1, 1, "R11 user wipe i");
    idle("R2 gap");
  endtask

  task automatic t_reserved_codes;
    for (int op = 13; op < 16; op++)
      drive(op, op[0], 0, 0, 0, 0, "R12 reserved code");
    idle("R2 gap");
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 16; p++)
          drive(op, s[0], p[0], p[1], p[2], p[3], tag_of(op));
    idle("R2 sweep end");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mode_select();
    t_load_store();
    t_write_class();
    t_reserve();
    t_idiscard();
    t_prefetch();
    t_flush_clean();
    t_wipe_collide();
    t_wipe_user();
    t_reserved_codes();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule